// File: doc/BRIEF.md
# Per-Pin Interrupt Service and End-of-Interrupt Engine

This block keeps the request state of every input pin of an I/O interrupt controller and decides, each clock cycle, which pin (if any) is offered for delivery to the local interrupt controllers. Each pin's line is the OR of several independently driven sources. Each pin carries a mask, a trigger selection (edge or level) and a vector, all decoded elsewhere and supplied as static inputs. The block reports a delivery request (pin, vector, trigger kind). In the same cycle it takes back how many destinations accepted that request.

Level-triggered pins are gated by a remote-IRR bit that the block owns. The bit is set when a level delivery is accepted and cleared by an end-of-interrupt (EOI) broadcast carrying the matching vector. A pin that keeps requesting across back-to-back EOIs is counted. When the count reaches a storm limit, redelivery is postponed by a fixed number of cycles instead of happening at once. Edge pins report a coalesced event when a source asserts while the pin's line is already high.

Top module: `pin_service_core`

## Requirements
- R1: A pin's line level is the OR of its NSRC source inputs; the line takes each source's value one clock edge after it is applied, and any single source alone can raise the line.
- R2: A masked pin (cfg_mask bit = 1) is never offered for delivery; after reset no delivery, remote-IRR or coalesced bit is active.
- R3: A level pin (cfg_level bit = 1) delivered with dlv_accept > 0 has its remote-IRR bit set at the next edge and is not offered again while that bit is set; with dlv_accept = 0 the bit stays clear and the pin is offered again.
- R4: An edge pin (cfg_level bit = 0) is offered exactly once per rise of its line; a source that rises while the line is already high sets that pin's coalesced bit for one cycle and causes no delivery.
- R5: When several pins are ready, the lowest-numbered pin is offered first, one pin per cycle.
- R6: Configuring a pin as level while its line is high and its remote-IRR bit is clear makes it ready at once; configuring a pin as edge clears its remote-IRR bit at the next edge.
- R7: A non-directed EOI (eoi_directed = 0) clears the remote-IRR bit of every level pin whose vector equals eoi_vector, and a pin still requesting and unmasked is offered again immediately; a directed EOI or a vector mismatch leaves remote IRR unchanged.
- R8: Each qualifying EOI on a pin that is unmasked and still requesting advances that pin's successive-EOI count; the EOI that brings it to STORM_LIMIT resets the count and holds the pin instead of redelivering; an EOI finding the pin masked or idle resets the count to 0.
- R9: Held pins are released together DEFER_CYCLES clock edges after the hold begins, and each released pin that is still requesting with remote IRR clear is then offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NPIN*NSRC | Source levels, pin p at bits [p*NSRC +: NSRC] |
| cfg_mask | input | NPIN | Per-pin mask, 1 = masked |
| cfg_level | input | NPIN | Per-pin trigger, 1 = level, 0 = edge |
| cfg_vector | input | NPIN*VEC_W | Per-pin vector, pin p at bits [p*VEC_W +: VEC_W] |
| eoi_valid | input | 1 | One-cycle EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| eoi_directed | input | 1 | 1 = directed-EOI mode, broadcast ignored |
| dlv_accept | input | ACC_W | Number of destinations accepting the current request |
| dlv_valid | output | 1 | A delivery request is offered this cycle |
| dlv_pin | output | $clog2(NPIN) | Pin being delivered |
| dlv_vector | output | VEC_W | Vector of that pin |
| dlv_level | output | 1 | Trigger kind of that pin, 1 = level |
| rirr | output | NPIN | Remote-IRR bits |
| coalesced | output | NPIN | One-cycle coalesced indication per pin |

## Verification
The properties take dlv_accept to be the destinations' answer for the request offered in the same cycle, and eoi_valid to be a single-cycle strobe whose vector and mode are steady while it is high. The bench changes every input only on the falling clock edge, so configuration, source levels and EOIs are steady across each rising edge. It holds dlv_accept constant within each scenario, so the count always belongs to the request on offer. The storm test uses small STORM_LIMIT and DEFER_CYCLES overrides, which keeps the hold window short enough to time exactly.

// File: rtl/pin_service_pkg.sv
package pin_service_pkg;
  // Successive-EOI count state returned by the storm logic.
  typedef enum logic [1:0] {
    EOI_NONE  = 2'd0,
    EOI_REDO  = 2'd1,
    EOI_TRIP  = 2'd2,
    EOI_CLEAR = 2'd3
  } eoi_act_t;
endpackage

// File: rtl/svc_line_track.sv
module svc_line_track #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            trig_level,
  input  logic            dlv_hit,
  output logic            line_q,
  output logic            pend,
  output logic            coal
);
  logic [NSRC-1:0] src_q;
  logic            line_d, rise, any_src_rise;
  logic            pend_nx, coal_nx;

  always_comb begin
    line_d       = |src;
    rise         = line_d & ~line_q;
    any_src_rise = |(src & ~src_q);
    pend_nx      = pend;
    if (dlv_hit) pend_nx = 1'b0;
    if (rise)    pend_nx = 1'b1;
    if (trig_level) pend_nx = 1'b0;
    coal_nx      = ~trig_level & line_q & any_src_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      line_q <= 1'b0;
      pend   <= 1'b0;
      coal   <= 1'b0;
    end else begin
      src_q  <= src;
      line_q <= line_d;
      pend   <= pend_nx;
      coal   <= coal_nx;
    end
  end
endmodule

// File: rtl/svc_pick.sv
module svc_pick #(
  parameter int NPIN = 4,
  localparam int PIN_W = $clog2(NPIN)
) (
  input  logic [NPIN-1:0]  ready,
  output logic             found,
  output logic [PIN_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (ready[i]) begin
        found = 1'b1;
        idx   = PIN_W'(i);
      end
    end
  end
endmodule

// File: rtl/svc_eoi_storm.sv
module svc_eoi_storm
  import pin_service_pkg::*;
#(
  parameter int NPIN         = 4,
  parameter int VEC_W        = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 2000000,
  localparam int CNT_W = $clog2(STORM_LIMIT + 1),
  localparam int TMR_W = $clog2(DEFER_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eoi_valid,
  input  logic [VEC_W-1:0]      eoi_vector,
  input  logic                  eoi_directed,
  input  logic [NPIN*VEC_W-1:0] cfg_vector,
  input  logic [NPIN-1:0]       cfg_level,
  input  logic [NPIN-1:0]       cfg_mask,
  input  logic [NPIN-1:0]       line_q,
  output logic [NPIN-1:0]       eoi_clr,
  output logic [NPIN-1:0]       hold
);
  logic [NPIN-1:0]  trip;
  logic [TMR_W-1:0] tmr, tmr_nx;
  logic [NPIN-1:0]  hold_nx;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [CNT_W-1:0] cnt, cnt_nx;
    eoi_act_t         act;

    always_comb begin
      act = EOI_NONE;
      if (eoi_valid && !eoi_directed && cfg_level[p] &&
          cfg_vector[p*VEC_W +: VEC_W] == eoi_vector) begin
        if (!cfg_mask[p] && line_q[p])
          act = (cnt == CNT_W'(STORM_LIMIT - 1)) ? EOI_TRIP : EOI_REDO;
        else
          act = EOI_CLEAR;
      end
      eoi_clr[p] = (act != EOI_NONE);
      trip[p]    = (act == EOI_TRIP);
      unique case (act)
        EOI_REDO: cnt_nx = cnt + 1'b1;
        EOI_NONE: cnt_nx = cnt;
        default:  cnt_nx = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (act != EOI_NONE) cnt <= cnt_nx;
    end
  end

  // One shared deferral timer; a trip while idle or expiring restarts it.
  always_comb begin
    hold_nx = hold;
    tmr_nx  = tmr;
    if (tmr == TMR_W'(1)) begin
      hold_nx = '0;
      tmr_nx  = '0;
    end else if (tmr != '0) begin
      tmr_nx = tmr - 1'b1;
    end
    hold_nx = hold_nx | trip;
    if (|trip && tmr_nx == '0) tmr_nx = TMR_W'(DEFER_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      tmr  <= '0;
    end else begin
      hold <= hold_nx;
      tmr  <= tmr_nx;
    end
  end
endmodule

// File: rtl/pin_service_core.sv
module pin_service_core #(
  parameter int NPIN         = 4,
  parameter int NSRC         = 2,
  parameter int VEC_W        = 8,
  parameter int ACC_W        = 4,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 2000000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPIN*NSRC-1:0]       src_level,
  input  logic [NPIN-1:0]            cfg_mask,
  input  logic [NPIN-1:0]            cfg_level,
  input  logic [NPIN*VEC_W-1:0]      cfg_vector,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vector,
  input  logic                       eoi_directed,
  input  logic [ACC_W-1:0]           dlv_accept,
  output logic                       dlv_valid,
  output logic [$clog2(NPIN)-1:0]    dlv_pin,
  output logic [VEC_W-1:0]           dlv_vector,
  output logic                       dlv_level,
  output logic [NPIN-1:0]            rirr,
  output logic [NPIN-1:0]            coalesced
);
  logic [NPIN-1:0] line_q, pend, hold, eoi_clr, ready, grant, rirr_nx;

  assign grant = dlv_valid ? (NPIN'(1) << dlv_pin) : '0;

  for (genvar p = 0; p < NPIN; p++) begin : g_line
    svc_line_track #(.NSRC(NSRC)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (src_level[p*NSRC +: NSRC]),
      .trig_level (cfg_level[p]),
      .dlv_hit    (grant[p]),
      .line_q     (line_q[p]),
      .pend       (pend[p]),
      .coal       (coalesced[p])
    );
  end

  svc_eoi_storm #(
    .NPIN(NPIN), .VEC_W(VEC_W),
    .STORM_LIMIT(STORM_LIMIT), .DEFER_CYCLES(DEFER_CYCLES)
  ) u_storm (
    .clk          (clk),
    .rst_n        (rst_n),
    .eoi_valid    (eoi_valid),
    .eoi_vector   (eoi_vector),
    .eoi_directed (eoi_directed),
    .cfg_vector   (cfg_vector),
    .cfg_level    (cfg_level),
    .cfg_mask     (cfg_mask),
    .line_q       (line_q),
    .eoi_clr      (eoi_clr),
    .hold         (hold)
  );

  always_comb begin
    ready = ~cfg_mask & ((cfg_level & line_q & ~rirr & ~hold) |
                         (~cfg_level & pend));
  end

  svc_pick #(.NPIN(NPIN)) u_pick (
    .ready (ready),
    .found (dlv_valid),
    .idx   (dlv_pin)
  );

  always_comb begin
    dlv_vector = cfg_vector[dlv_pin*VEC_W +: VEC_W];
    dlv_level  = cfg_level[dlv_pin];
    rirr_nx    = (rirr & ~eoi_clr & cfg_level) |
                 (grant & cfg_level & {NPIN{dlv_accept != '0}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rirr <= '0;
    else        rirr <= rirr_nx;
  end
endmodule

// File: rtl/pin_service_chk.sv
module pin_service_chk #(
  parameter int NPIN  = 4,
  parameter int VEC_W = 8,
  parameter int ACC_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPIN-1:0]         cfg_mask,
  input logic [NPIN-1:0]         cfg_level,
  input logic                    eoi_valid,
  input logic                    eoi_directed,
  input logic [ACC_W-1:0]        dlv_accept,
  input logic                    dlv_valid,
  input logic [$clog2(NPIN)-1:0] dlv_pin,
  input logic                    dlv_level,
  input logic [NPIN-1:0]         rirr,
  input logic [NPIN-1:0]         coalesced
);
  assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !cfg_mask[dlv_pin]);

  assert_rirr_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_level) |-> !rirr[dlv_pin]);

  assert_rirr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_level && dlv_accept != '0) |=> rirr[$past(dlv_pin)]);

  assert_coal_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid || !eoi_valid) |=> ((coalesced & $past(cfg_level)) == '0));

  assert_edge_drops_rirr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (~cfg_level != '0) |=> ((rirr & ~$past(cfg_level)) == '0));

  assert_directed_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_directed && !dlv_valid) |=>
      (rirr == ($past(rirr) & $past(cfg_level))));
endmodule

bind pin_service_core pin_service_chk #(
  .NPIN(NPIN), .VEC_W(VEC_W), .ACC_W(ACC_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mask     (cfg_mask),
  .cfg_level    (cfg_level),
  .eoi_valid    (eoi_valid),
  .eoi_directed (eoi_directed),
  .dlv_accept   (dlv_accept),
  .dlv_valid    (dlv_valid),
  .dlv_pin      (dlv_pin),
  .dlv_level    (dlv_level),
  .rirr         (rirr),
  .coalesced    (coalesced)
);

// File: tb/pin_service_core_tb_top.sv
`timescale 1ns/1ps
module pin_service_core_tb_top;
  localparam int NPIN = 4, NSRC = 2, VEC_W = 8, ACC_W = 4;
  localparam int LIM = 4, DEF = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                  rst_n;
  logic [NPIN*NSRC-1:0]  src;
  logic [NPIN-1:0]       mask, lvl;
  logic [NPIN*VEC_W-1:0] vec;
  logic                  eoi_valid, eoi_dir;
  logic [VEC_W-1:0]      eoi_vec;
  logic [ACC_W-1:0]      acc;
  logic                  dlv_valid, dlv_level;
  logic [1:0]            dlv_pin;
  logic [VEC_W-1:0]      dlv_vector;
  logic [NPIN-1:0]       rirr, coalesced;

  pin_service_core #(
    .NPIN(NPIN), .NSRC(NSRC), .VEC_W(VEC_W), .ACC_W(ACC_W),
    .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .src_level(src), .cfg_mask(mask),
    .cfg_level(lvl), .cfg_vector(vec), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vec), .eoi_directed(eoi_dir), .dlv_accept(acc),
    .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
    .dlv_level(dlv_level), .rirr(rirr), .coalesced(coalesced)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_dlv(input string req, input int pin);
    chk({req, " valid"}, int'(dlv_valid), 1);
    chk({req, " pin"}, int'(dlv_pin), pin);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src = '0; mask = '1; lvl = '0;
    for (int p = 0; p < NPIN; p++) vec[p*VEC_W +: VEC_W] = VEC_W'(8'h30 + p);
    eoi_valid = 1'b0; eoi_vec = '0; eoi_dir = 1'b0; acc = 4'd1;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic send_eoi(input logic [VEC_W-1:0] v, input logic d);
    eoi_valid = 1'b1; eoi_vec = v; eoi_dir = d;
    step(1);
    eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 reset dlv_valid", int'(dlv_valid), 0);
    chk("R2 reset rirr", int'(rirr), 0);
    chk("R2 reset coalesced", int'(coalesced), 0);
  endtask

  task automatic t_edge();
    do_reset();
    mask[1] = 1'b0; step(1);
    src[2] = 1'b1; step(1);
    expect_dlv("R4 edge first", 1);
    chk("R4 edge vector", int'(dlv_vector), 8'h31);
    step(1);
    chk("R4 edge once", int'(dlv_valid), 0);
    src[3] = 1'b1; step(1);
    chk("R4 coalesced", int'(coalesced), 4'b0010);
    chk("R4 coalesced no dlv", int'(dlv_valid), 0);
    step(1);
    chk("R4 coalesced one cycle", int'(coalesced), 0);
    src[2] = 1'b0; step(2);
    chk("R1 line held by other source", int'(dlv_valid), 0);
    src[3] = 1'b0; step(1);
    src[3] = 1'b1; step(1);
    expect_dlv("R1 second source alone", 1);
  endtask

  task automatic t_mask();
    do_reset();
    lvl[2] = 1'b1; src[4] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R2 masked level quiet", int'(dlv_valid), 0);
    end
    mask[2] = 1'b0; #1;
    expect_dlv("R2 unmasked level", 2);
  endtask

  task automatic t_level();
    do_reset();
    lvl[2] = 1'b1; mask[2] = 1'b0; src[4] = 1'b1; step(1);
    expect_dlv("R3 level dlv", 2);
    chk("R3 level vector", int'(dlv_vector), 8'h32);
    step(1);
    chk("R3 rirr set", int'(rirr), 4'b0100);
    chk("R3 no redelivery", int'(dlv_valid), 0);
    send_eoi(8'h32, 1'b1);
    chk("R7 directed keeps rirr", int'(rirr), 4'b0100);
    chk("R7 directed no dlv", int'(dlv_valid), 0);
    send_eoi(8'h55, 1'b0);
    chk("R7 mismatch keeps rirr", int'(rirr), 4'b0100);
    send_eoi(8'h32, 1'b0);
    chk("R7 eoi clears rirr", int'(rirr), 0);
    expect_dlv("R7 eoi redelivers", 2);
    step(1);
    chk("R3 rirr set again", int'(rirr), 4'b0100);
    src[4] = 1'b0; step(1);
    send_eoi(8'h32, 1'b0);
    chk("R7 idle eoi clears", int'(rirr), 0);
    chk("R7 idle no dlv", int'(dlv_valid), 0);
    acc = 4'd0; src[4] = 1'b1; step(1);
    expect_dlv("R3 unaccepted dlv", 2);
    step(1);
    chk("R3 unaccepted rirr clear", int'(rirr), 0);
    expect_dlv("R3 unaccepted offered again", 2);
    acc = 4'd1;
  endtask

  task automatic t_prio();
    do_reset();
    lvl[0] = 1'b1; lvl[3] = 1'b1; mask[0] = 1'b0; mask[3] = 1'b0;
    src[0] = 1'b1; src[6] = 1'b1; step(1);
    expect_dlv("R5 lowest first", 0);
    step(1);
    expect_dlv("R5 next pin", 3);
    step(1);
    chk("R5 all served", int'(dlv_valid), 0);
  endtask

  task automatic t_switch();
    do_reset();
    mask[1] = 1'b0; src[2] = 1'b1; step(1);
    expect_dlv("R6 edge dlv", 1);
    step(1);
    chk("R6 edge served", int'(dlv_valid), 0);
    lvl[1] = 1'b1; #1;
    expect_dlv("R6 to level ready", 1);
    step(1);
    chk("R6 level rirr", int'(rirr), 4'b0010);
    lvl[1] = 1'b0; step(1);
    chk("R6 to edge clears rirr", int'(rirr), 0);
    chk("R6 to edge no dlv", int'(dlv_valid), 0);
  endtask

  task automatic t_storm();
    int n;
    do_reset();
    lvl[1:0] = 2'b11; mask[1:0] = 2'b00;
    vec[0 +: VEC_W] = 8'h40; vec[VEC_W +: VEC_W] = 8'h40;
    src[0] = 1'b1; src[2] = 1'b1; step(1);
    expect_dlv("R8 initial pin0", 0);
    step(1);
    expect_dlv("R8 initial pin1", 1);
    step(1);
    for (int k = 1; k < LIM; k++) begin
      send_eoi(8'h40, 1'b0);
      expect_dlv("R8 immediate redelivery pin0", 0);
      step(1);
      expect_dlv("R8 immediate redelivery pin1", 1);
      step(1);
    end
    send_eoi(8'h40, 1'b0);
    chk("R8 storm holds", int'(dlv_valid), 0);
    chk("R8 storm rirr clear", int'(rirr), 0);
    n = 1;
    while (!dlv_valid && n < DEF + 10) begin
      step(1);
      n++;
    end
    chk("R9 release delay in range", int'(n >= DEF && n <= DEF + 2), 1);
    expect_dlv("R9 released pin0", 0);
    step(1);
    expect_dlv("R9 released pin1", 1);
    step(1);
    for (int k = 1; k < LIM; k++) begin
      send_eoi(8'h40, 1'b0);
      step(2);
    end
    mask[1:0] = 2'b11;
    send_eoi(8'h40, 1'b0);
    chk("R8 masked eoi no dlv", int'(dlv_valid), 0);
    mask[1:0] = 2'b00; #1;
    expect_dlv("R8 unmask dlv pin0", 0);
    step(1);
    expect_dlv("R8 unmask dlv pin1", 1);
    step(1);
    send_eoi(8'h40, 1'b0);
    expect_dlv("R8 count was reset", 0);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_mask();
    t_level();
    t_prio();
    t_switch();
    t_storm();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule